// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 13-bit instruction address of a small processor core and chooses its next value on every clock edge. With no request present it advances by one. A return request reloads the whole address from a value supplied by an external return stack. A jump or call request forms the address from an 11-bit opcode field plus two page bits. A software write to the low byte replaces the low eight bits and, in the same edge, the upper five bits.

The upper five address bits are never written directly. A separate 5-bit page latch holds them, and software writes that latch over the same data bus. The latch is copied into the counter only when a low-byte write or a jump takes effect. A jump uses just the top two latch bits. The block also shows the readable low byte and the address of the following instruction, which a caller pushes onto its stack when a call is taken. Decode, program memory and the stack storage are not part of this block.

Top module: `paged_pc_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both the program counter and the page latch to zero. The cleared latch shows up as zero upper bits after the first low-byte write.
- R2: On an edge with no request, `pc_q` becomes `pc_q + 1` modulo 2^13, so 0x1FFF wraps to 0x0000.
- R3: `pcl_rd` always equals `pc_q[7:0]`.
- R4: On an edge where `pcl_we` is the winning request, `pc_q[7:0]` takes `wr_data` and `pc_q[12:8]` takes the page latch value held before that edge.
- R5: `lat_we` stores `wr_data[4:0]` in the page latch without changing `pc_q`, which still follows its own request that edge. When `lat_we` and `pcl_we` arrive together, the counter uses the old latch value.
- R6: On an edge where `jmp_req` is the winning request, `pc_q` becomes `{latch[4:3], jmp_addr[10:0]}`.
- R7: On an edge with `ret_req`, `pc_q` becomes `ret_addr` in full, whatever the latch holds.
- R8: `push_addr` always equals `pc_q + 1` modulo 2^13. During a call cycle this is the address of the instruction after the call.
- R9: When several requests arrive together, priority is `ret_req`, then `jmp_req`, then `pcl_we`, then increment.
- R10: Return and jump requests never change the page latch. A later low-byte write shows the unchanged latch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_req | input | 1 | Load counter from return stack value |
| jmp_req | input | 1 | Jump or call using opcode address field |
| pcl_we | input | 1 | Software write of the low address byte |
| lat_we | input | 1 | Software write of the page latch |
| wr_data | input | 8 | Software write data (latch uses bits 4:0) |
| jmp_addr | input | 11 | Opcode address field |
| ret_addr | input | 13 | Address popped from the return stack |
| pc_q | output | 13 | Current program counter |
| pcl_rd | output | 8 | Readable low byte of the counter |
| push_addr | output | 13 | Next-instruction address for a call push |

## Verification
Every change to `pc_q` or to the page latch is due one clock edge after the request is applied. `pcl_rd` and `push_addr` follow `pc_q` combinationally in that same cycle. The bench applies each stimulus 1 ns after a rising edge and compares all three outputs 1 ns after the next rising edge against its own model. This keeps every sample clear of the active edge. The latch cannot be read directly, so its value is checked one edge later by issuing a low-byte write and inspecting the upper counter bits.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int PC_WIDTH  = 13;
    localparam int LO_WIDTH  = 8;
    localparam int JMP_WIDTH = 11;

    typedef enum logic [1:0] {
        SRC_INC = 2'd0,
        SRC_PCL = 2'd1,
        SRC_JMP = 2'd2,
        SRC_RET = 2'd3
    } pc_src_e;

    typedef struct packed {
        logic ret;
        logic jmp;
        logic pcl;
    } pc_req_t;

    // Fixed priority: return, jump, low-byte write, increment.
    function automatic pc_src_e resolve_src(input pc_req_t req);
        if (req.ret)      return SRC_RET;
        else if (req.jmp) return SRC_JMP;
        else if (req.pcl) return SRC_PCL;
        else              return SRC_INC;
    endfunction

endpackage

// File: rtl/pc_page_latch.sv
module pc_page_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/pc_src_arbiter.sv
module pc_src_arbiter
    import pc_pkg::*;
(
    input  pc_req_t req,
    output pc_src_e src
);
    always_comb src = resolve_src(req);
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
    import pc_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int JMP_W = 11
) (
    input  pc_src_e                   src,
    input  logic [PC_W-1:0]           pc_cur,
    input  logic [PC_W-LO_W-1:0]      lat,
    input  logic [LO_W-1:0]           wr_data,
    input  logic [JMP_W-1:0]          jmp_addr,
    input  logic [PC_W-1:0]           ret_addr,
    output logic [PC_W-1:0]           pc_inc,
    output logic [PC_W-1:0]           pc_next
);
    localparam int LAT_W = PC_W - LO_W;
    localparam int PG_W  = PC_W - JMP_W;

    logic [PG_W-1:0] page_bits;

    assign pc_inc    = pc_cur + PC_W'(1);
    assign page_bits = lat[LAT_W-1 -: PG_W];

    always_comb begin
        unique case (src)
            SRC_RET: pc_next = ret_addr;
            SRC_JMP: pc_next = {page_bits, jmp_addr};
            SRC_PCL: pc_next = {lat, wr_data};
            default: pc_next = pc_inc;
        endcase
    end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
    import pc_pkg::*;
#(
    parameter int PC_W  = PC_WIDTH,
    parameter int LO_W  = LO_WIDTH,
    parameter int JMP_W = JMP_WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ret_req,
    input  logic              jmp_req,
    input  logic              pcl_we,
    input  logic              lat_we,
    input  logic [LO_W-1:0]   wr_data,
    input  logic [JMP_W-1:0]  jmp_addr,
    input  logic [PC_W-1:0]   ret_addr,
    output logic [PC_W-1:0]   pc_q,
    output logic [LO_W-1:0]   pcl_rd,
    output logic [PC_W-1:0]   push_addr
);
    localparam int LAT_W = PC_W - LO_W;

    pc_req_t          req;
    pc_src_e          src;
    logic [LAT_W-1:0] lat_q;
    logic [PC_W-1:0]  pc_next;
    logic [PC_W-1:0]  pc_inc;

    assign req = '{ret: ret_req, jmp: jmp_req, pcl: pcl_we};

    pc_src_arbiter u_arb (
        .req (req),
        .src (src)
    );

    pc_page_latch #(.W(LAT_W)) u_latch (
        .clk (clk),
        .rst (rst),
        .we  (lat_we),
        .d   (wr_data[LAT_W-1:0]),
        .q   (lat_q)
    );

    pc_next_calc #(.PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W)) u_calc (
        .src      (src),
        .pc_cur   (pc_q),
        .lat      (lat_q),
        .wr_data  (wr_data),
        .jmp_addr (jmp_addr),
        .ret_addr (ret_addr),
        .pc_inc   (pc_inc),
        .pc_next  (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pcl_rd    = pc_q[LO_W-1:0];
    assign push_addr = pc_inc;
endmodule

// File: rtl/paged_pc_chk.sv
module paged_pc_chk #(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int JMP_W = 11
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ret_req,
    input logic                  jmp_req,
    input logic                  pcl_we,
    input logic                  lat_we,
    input logic [LO_W-1:0]       wr_data,
    input logic [JMP_W-1:0]      jmp_addr,
    input logic [PC_W-1:0]       ret_addr,
    input logic [PC_W-1:0]       pc_q,
    input logic [PC_W-LO_W-1:0]  lat_q
);
    localparam int LAT_W = PC_W - LO_W;
    localparam int PG_W  = PC_W - JMP_W;

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            AST_RESET_CLEAR: assert (pc_q == '0 && lat_q == '0); // R1
        end
    end

    AST_INCR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ret_req && !jmp_req && !pcl_we) |=> pc_q == $past(pc_q) + PC_W'(1)); // R2

    AST_PCL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (pcl_we && !ret_req && !jmp_req) |=> pc_q == {$past(lat_q), $past(wr_data)}); // R4

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        lat_we |=> lat_q == $past(wr_data[LAT_W-1:0])); // R5

    AST_JUMP_PAGE: assert property (@(posedge clk) disable iff (rst)
        (jmp_req && !ret_req) |=> pc_q == {$past(lat_q[LAT_W-1 -: PG_W]), $past(jmp_addr)}); // R6

    AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst)
        ret_req |=> pc_q == $past(ret_addr)); // R7

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !lat_we |=> $stable(lat_q)); // R10
endmodule

bind paged_pc_unit paged_pc_chk #(.PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ret_req  (ret_req),
    .jmp_req  (jmp_req),
    .pcl_we   (pcl_we),
    .lat_we   (lat_we),
    .wr_data  (wr_data),
    .jmp_addr (jmp_addr),
    .ret_addr (ret_addr),
    .pc_q     (pc_q),
    .lat_q    (lat_q)
);

// File: tb/paged_pc_unit_test.sv
`timescale 1ns/1ps
module paged_pc_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        ret_req, jmp_req, pcl_we, lat_we;
    logic [7:0]  wr_data;
    logic [10:0] jmp_addr;
    logic [12:0] ret_addr;
    logic [12:0] pc_q;
    logic [7:0]  pcl_rd;
    logic [12:0] push_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [12:0] m_pc;
    logic [4:0]  m_lat;

    always #2.5 clk = ~clk;

    paged_pc_unit uut (
        .clk(clk), .rst(rst), .ret_req(ret_req), .jmp_req(jmp_req),
        .pcl_we(pcl_we), .lat_we(lat_we), .wr_data(wr_data),
        .jmp_addr(jmp_addr), .ret_addr(ret_addr),
        .pc_q(pc_q), .pcl_rd(pcl_rd), .push_addr(push_addr)
    );

    function automatic logic [12:0] exp_next(
        input logic [12:0] pc, input logic [4:0] lat,
        input logic r, input logic j, input logic w,
        input logic [12:0] ra, input logic [10:0] ja, input logic [7:0] wd);
        if (r) return ra;
        if (j) return {lat[4:3], ja};
        if (w) return {lat, wd};
        return pc + 13'd1;
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ret_req = 0; jmp_req = 0; pcl_we = 0; lat_we = 0;
        wr_data = '0; jmp_addr = '0; ret_addr = '0;
    endtask

    // Apply current inputs for one edge, update model, compare outputs.
    task automatic step(input string tag);
        logic [12:0] nxt;
        nxt = exp_next(m_pc, m_lat, ret_req, jmp_req, pcl_we, ret_addr, jmp_addr, wr_data);
        if (lat_we) m_lat = wr_data[4:0];
        m_pc = nxt;
        @(posedge clk); #1;
        check(tag, pc_q, m_pc);
        check("R3 low byte", {5'd0, pcl_rd}, {5'd0, m_pc[7:0]});
        check("R8 push addr", push_addr, m_pc + 13'd1);
        idle_inputs();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pc", pc_q, 13'd0);
        check("R8 push after reset", push_addr, 13'd1);
        rst = 0;
        m_pc = 0; m_lat = 0;

        // R1: latch cleared -> low-byte write gives zero upper bits
        pcl_we = 1; wr_data = 8'h34; step("R1 latch cleared");

        // R5: latch write alone does not disturb increment
        lat_we = 1; wr_data = 8'hFF; step("R5 latch write no pc effect");

        // R4: low-byte write copies latch -> 0x1FFF, then R2 wrap
        pcl_we = 1; wr_data = 8'hFF; step("R4 pcl write");
        check("R4 full value", pc_q, 13'h1FFF);
        step("R2 wrap");
        check("R2 wrap zero", pc_q, 13'h0000);

        // R5: simultaneous latch and pcl write uses old latch (0x1F)
        lat_we = 1; pcl_we = 1; wr_data = 8'h02; step("R5 old latch used");
        check("R5 old latch value", pc_q, 13'h1F02);

        // R6: jump with latch 0x15 -> page bits 2'b10
        lat_we = 1; wr_data = 8'h15; step("R5 latch load");
        jmp_req = 1; jmp_addr = 11'h7A5; step("R6 jump");
        check("R6 jump value", pc_q, 13'h17A5);

        // R7: return ignores latch
        ret_req = 1; ret_addr = 13'h0ABC; step("R7 return");
        // R10: latch unchanged after jump/return
        pcl_we = 1; wr_data = 8'h11; step("R10 latch kept");
        check("R10 latch value", pc_q, 13'h1511);

        // R9: priorities
        ret_req = 1; jmp_req = 1; pcl_we = 1; ret_addr = 13'h0123;
        jmp_addr = 11'h456; wr_data = 8'h78; step("R9 ret wins");
        jmp_req = 1; pcl_we = 1; jmp_addr = 11'h001; wr_data = 8'h99; step("R9 jmp over pcl");
        check("R9 jmp value", pc_q, 13'h1001);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom_range(0, 99);
            ret_req  = (k < 10);
            jmp_req  = (k >= 5 && k < 25);
            pcl_we   = (k >= 20 && k < 40);
            lat_we   = ($urandom_range(0, 3) == 0);
            wr_data  = 8'($urandom);
            jmp_addr = 11'($urandom);
            ret_addr = 13'($urandom);
            step(ret_req ? "R7 random" : jmp_req ? "R6 random" :
                 pcl_we ? "R4 random" : "R2 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule